// File: doc/BRIEF.md
# ALU Status Flag Register

This unit sits beside an integer ALU and turns each completed operation into the six arithmetic status flags. It keeps them in a 16-bit packed flag word together with three control flags: single-step trap, interrupt enable and string direction. The ALU datapath stays outside the unit. It supplies the two operands, the result, the carry or borrow out of the selected width, an operation kind and the operand size. The unit derives every other flag from those values.

Status flags are written only in a cycle where the update enable is high and the operation kind is a defined one. The control flags do not depend on the ALU. Each one has its own set and clear strobe, and clear wins when both strobes are high. The packed word comes straight from registers, so a change is visible in the cycle after the edge that captures it.

The unit has no sequencer. It has one register stage for the status flags and one for each control flag. Both stages are reset asynchronously to zero.

Top module: `alu_flag_unit`

## Requirements
- R1: After reset, every bit of `flags_o` is 0.
- R2: The operation kind is encoded as 00 add, 01 subtract, 10 logical and 11 none. On an add or subtract update, CF (bit 0) takes the value of `alu_cy` from the same cycle. `alu_cy` is the carry out of an add or the borrow of a subtract at the selected width.
- R3: On an add, AF (bit 4) is 1 when the low nibbles produce a carry into bit 4. On a subtract, AF is 1 when the low nibble of A is smaller than the low nibble of B.
- R4: On any defined update, PF (bit 2) is 1 when bits 7..0 of the result hold an even number of ones. This applies for byte and word size alike.
- R5: ZF (bit 6) is 1 when the result is zero. SF (bit 7) is the top bit of the result. With `is_word` = 0 both flags use bits 7..0; with `is_word` = 1 they use bits 15..0.
- R6: On an add or subtract, OF (bit 11) is 1 when the signed result at the selected width is out of range.
- R7: A logical update clears CF and OF. It keeps AF at its previous value and updates PF, ZF and SF from the result.
- R8: The control flags sit at TF bit 8, IF bit 9 and DF bit 10, which match strobe indices 0, 1 and 2. A set strobe makes the flag 1 and a clear strobe makes it 0. If both strobes are high, clear wins. No status update changes these flags.
- R9: Bits 1, 3, 5 and 12..15 of `flags_o` are always 0.
- R10: When `upd_en` is 0, or the operation kind is 11, all six status flags keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| upd_en | input | 1 | Writes the status flags from this cycle's operation |
| op_kind | input | 2 | 00 add, 01 subtract, 10 logical, 11 none |
| is_word | input | 1 | 0 byte size, 1 word size |
| opnd_a | input | 16 | First operand |
| opnd_b | input | 16 | Second operand |
| alu_res | input | 16 | ALU result |
| alu_cy | input | 1 | Carry or borrow out of the selected width |
| ctl_set | input | 3 | Control flag set strobes (0 trap, 1 interrupt, 2 direction) |
| ctl_clr | input | 3 | Control flag clear strobes, same indices |
| flags_o | output | 16 | Packed flag word |

## Verification
The assertions check four things on every cycle: the unused bits stay at zero, a logical update clears CF and OF and keeps AF, the status flags hold when no defined update occurs, and a clear strobe leaves its control flag at zero. The values of parity, zero, sign, auxiliary carry and signed overflow at each operand size can only be shown by the bench. The bench compares these values against its own arithmetic over random and directed operands, including carry, borrow and overflow limits at both sizes.

// File: rtl/flag_pkg.sv
package flag_pkg;
    typedef enum logic [1:0] {
        OPK_ADD   = 2'b00,
        OPK_SUB   = 2'b01,
        OPK_LOGIC = 2'b10,
        OPK_NONE  = 2'b11
    } opk_e;

    localparam int FLAG_W  = 16;
    localparam int CTL_N   = 3;
    localparam int POS_CF  = 0;
    localparam int POS_PF  = 2;
    localparam int POS_AF  = 4;
    localparam int POS_ZF  = 6;
    localparam int POS_SF  = 7;
    localparam int POS_CTL = 8;   // TF, IF, DF at POS_CTL + index
    localparam int POS_OF  = 11;
    localparam logic [FLAG_W-1:0] USED_MASK = 16'h0FD5;
endpackage

// File: rtl/flag_status_calc.sv
module flag_status_calc
    import flag_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int BYTE_W = 8,
    parameter int NIB_W  = 4
) (
    input  logic [1:0]        op_kind,
    input  logic              is_word,
    input  logic [DATA_W-1:0] opnd_a,
    input  logic [DATA_W-1:0] opnd_b,
    input  logic [DATA_W-1:0] alu_res,
    input  logic              alu_cy,
    output logic              valid_op,
    output logic              af_write,
    output logic              cf_n,
    output logic              af_n,
    output logic              pf_n,
    output logic              zf_n,
    output logic              sf_n,
    output logic              of_n
);
    opk_e kind;
    logic a_top, b_top, r_top;
    logic [DATA_W-1:0] nib_x;

    always_comb begin
        kind     = opk_e'(op_kind);
        a_top    = is_word ? opnd_a[DATA_W-1]  : opnd_a[BYTE_W-1];
        b_top    = is_word ? opnd_b[DATA_W-1]  : opnd_b[BYTE_W-1];
        r_top    = is_word ? alu_res[DATA_W-1] : alu_res[BYTE_W-1];
        nib_x    = opnd_a ^ opnd_b ^ alu_res;
        valid_op = (kind != OPK_NONE);
        af_write = (kind == OPK_ADD) || (kind == OPK_SUB);
        pf_n     = ~^alu_res[BYTE_W-1:0];
        sf_n     = r_top;
        zf_n     = is_word ? (alu_res == '0) : (alu_res[BYTE_W-1:0] == '0);
        af_n     = nib_x[NIB_W];
        cf_n     = 1'b0;
        of_n     = 1'b0;
        unique case (kind)
            OPK_ADD: begin
                cf_n = alu_cy;
                of_n = (a_top == b_top) && (r_top != a_top);
            end
            OPK_SUB: begin
                cf_n = alu_cy;
                of_n = (a_top != b_top) && (r_top != a_top);
            end
            OPK_LOGIC, OPK_NONE: begin
                cf_n = 1'b0;
                of_n = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/flag_ctl_bit.sv
module flag_ctl_bit (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic q_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     q_o <= 1'b0;
        else if (clr_i) q_o <= 1'b0;
        else if (set_i) q_o <= 1'b1;
    end

    // R8: clear has priority
    a_r8_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> !q_o);
endmodule

// File: rtl/alu_flag_unit.sv
module alu_flag_unit
    import flag_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int BYTE_W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 upd_en,
    input  logic [1:0]           op_kind,
    input  logic                 is_word,
    input  logic [DATA_W-1:0]    opnd_a,
    input  logic [DATA_W-1:0]    opnd_b,
    input  logic [DATA_W-1:0]    alu_res,
    input  logic                 alu_cy,
    input  logic [CTL_N-1:0]     ctl_set,
    input  logic [CTL_N-1:0]     ctl_clr,
    output logic [FLAG_W-1:0]    flags_o
);
    logic valid_op, af_write;
    logic cf_n, af_n, pf_n, zf_n, sf_n, of_n;
    logic cf_q, af_q, pf_q, zf_q, sf_q, of_q;
    logic [CTL_N-1:0] ctl_q;
    logic wr_stat;

    flag_status_calc #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_calc (
        .op_kind (op_kind),
        .is_word (is_word),
        .opnd_a  (opnd_a),
        .opnd_b  (opnd_b),
        .alu_res (alu_res),
        .alu_cy  (alu_cy),
        .valid_op(valid_op),
        .af_write(af_write),
        .cf_n    (cf_n),
        .af_n    (af_n),
        .pf_n    (pf_n),
        .zf_n    (zf_n),
        .sf_n    (sf_n),
        .of_n    (of_n)
    );

    assign wr_stat = upd_en && valid_op;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cf_q <= 1'b0;
            af_q <= 1'b0;
            pf_q <= 1'b0;
            zf_q <= 1'b0;
            sf_q <= 1'b0;
            of_q <= 1'b0;
        end else if (wr_stat) begin
            cf_q <= cf_n;
            pf_q <= pf_n;
            zf_q <= zf_n;
            sf_q <= sf_n;
            of_q <= of_n;
            if (af_write) af_q <= af_n;
        end
    end

    for (genvar g = 0; g < CTL_N; g++) begin : g_ctl
        flag_ctl_bit u_bit (
            .clk  (clk),
            .rst_n(rst_n),
            .set_i(ctl_set[g]),
            .clr_i(ctl_clr[g]),
            .q_o  (ctl_q[g])
        );
    end

    always_comb begin
        flags_o = '0;
        flags_o[POS_CF] = cf_q;
        flags_o[POS_PF] = pf_q;
        flags_o[POS_AF] = af_q;
        flags_o[POS_ZF] = zf_q;
        flags_o[POS_SF] = sf_q;
        flags_o[POS_OF] = of_q;
        flags_o[POS_CTL +: CTL_N] = ctl_q;
    end

    // R9: unused positions stay zero
    a_r9_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (flags_o & ~USED_MASK) == '0);

    // R7: logical update clears CF and OF, keeps AF
    a_r7_logic_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && op_kind == OPK_LOGIC) |=> (!flags_o[POS_CF] && !flags_o[POS_OF]));
    a_r7_af_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && op_kind == OPK_LOGIC) |=> $stable(flags_o[POS_AF]));

    // R10: no defined update keeps the status flags
    a_r10_status_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!upd_en || op_kind == OPK_NONE) |=>
            $stable({flags_o[POS_OF], flags_o[POS_SF], flags_o[POS_ZF],
                     flags_o[POS_AF], flags_o[POS_PF], flags_o[POS_CF]}));

    // R8: control flags move only on strobes
    a_r8_ctl_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_set == '0 && ctl_clr == '0) |=> $stable(flags_o[POS_CTL +: CTL_N]));
endmodule

// File: tb/test_alu_flag_unit.sv
module test_alu_flag_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        upd_en = 1'b0;
    logic [1:0]  op_kind = 2'b11;
    logic        is_word = 1'b0;
    logic [15:0] opnd_a = '0, opnd_b = '0, alu_res = '0;
    logic        alu_cy = 1'b0;
    logic [2:0]  ctl_set = '0, ctl_clr = '0;
    logic [15:0] flags_o;

    int total = 0;
    int bad = 0;
    bit done = 0;

    // expected state
    bit e_cf, e_af, e_pf, e_zf, e_sf, e_of;
    bit [2:0] e_ctl;

    alu_flag_unit i_alu_flag_unit (
        .clk(clk), .rst_n(rst_n), .upd_en(upd_en), .op_kind(op_kind),
        .is_word(is_word), .opnd_a(opnd_a), .opnd_b(opnd_b),
        .alu_res(alu_res), .alu_cy(alu_cy), .ctl_set(ctl_set),
        .ctl_clr(ctl_clr), .flags_o(flags_o)
    );

    always #2 clk = ~clk;

    task automatic chk(input string req, input string what,
                       input logic [15:0] got, input logic [15:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
        end
    endtask

    function automatic int sx(input logic [15:0] v, input bit w);
        if (w) return int'($signed(v));
        return int'($signed(v[7:0]));
    endfunction

    task automatic check_all(input string tag);
        chk("R2", {tag, " CF"}, 16'(flags_o[0]), 16'(e_cf));
        chk("R4", {tag, " PF"}, 16'(flags_o[2]), 16'(e_pf));
        chk("R3", {tag, " AF"}, 16'(flags_o[4]), 16'(e_af));
        chk("R5", {tag, " ZF"}, 16'(flags_o[6]), 16'(e_zf));
        chk("R5", {tag, " SF"}, 16'(flags_o[7]), 16'(e_sf));
        chk("R6", {tag, " OF"}, 16'(flags_o[11]), 16'(e_of));
        chk("R8", {tag, " ctl"}, 16'(flags_o[10:8]), 16'(e_ctl));
        chk("R9", {tag, " unused"}, flags_o & 16'hF02A, 16'h0000);
    endtask

    // k: 0 add, 1 sub, 2 logic, 3 none
    task automatic step(input logic [1:0] k, input bit w, input logic [15:0] a,
                        input logic [15:0] b, input bit en,
                        input logic [2:0] s, input logic [2:0] c,
                        input string tag);
        logic [15:0] mask, r;
        logic [16:0] wide;
        bit cy, lc;
        int sr;
        mask = w ? 16'hFFFF : 16'h00FF;
        lc = 1'b0;
        cy = 1'b0;
        r = '0;
        case (k)
            2'd0: begin
                wide = {1'b0, a & mask} + {1'b0, b & mask};
                r = wide[15:0] & mask;
                cy = w ? wide[16] : wide[8];
            end
            2'd1: begin
                r = ((a & mask) - (b & mask)) & mask;
                cy = (a & mask) < (b & mask);
            end
            default: begin
                r = a[0] ? (a & b) : (a ^ b);
                cy = bit'($urandom_range(1, 0));
                lc = 1'b1;
            end
        endcase
        @(negedge clk);
        upd_en = en; op_kind = k; is_word = w; opnd_a = a; opnd_b = b;
        alu_res = r; alu_cy = cy; ctl_set = s; ctl_clr = c;
        for (int i = 0; i < 3; i++) begin
            if (c[i]) e_ctl[i] = 1'b0;
            else if (s[i]) e_ctl[i] = 1'b1;
        end
        if (en && k != 2'd3) begin
            e_pf = ~^r[7:0];
            e_zf = w ? (r == 0) : (r[7:0] == 0);
            e_sf = w ? r[15] : r[7];
            if (lc) begin
                e_cf = 0; e_of = 0;
            end else begin
                e_cf = cy;
                if (k == 2'd0) begin
                    e_af = (32'(a[3:0]) + 32'(b[3:0])) > 15;
                    sr = sx(a, w) + sx(b, w);
                end else begin
                    e_af = a[3:0] < b[3:0];
                    sr = sx(a, w) - sx(b, w);
                end
                e_of = w ? (sr > 32767 || sr < -32768) : (sr > 127 || sr < -128);
            end
        end
        @(posedge clk);
        #1;
        check_all(tag);
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        e_cf = 0; e_af = 0; e_pf = 0; e_zf = 0; e_sf = 0; e_of = 0; e_ctl = '0;
        repeat (3) @(posedge clk);
        #1;
        chk("R1", "reset word", flags_o, 16'h0000);
        @(negedge clk);
        rst_n = 1'b1;

        // directed corners
        step(2'd0, 0, 16'h00FF, 16'h0001, 1, 0, 0, "R2 byte add carry");
        step(2'd0, 1, 16'h00FF, 16'h0001, 1, 0, 0, "R5 word add no zero");
        step(2'd0, 0, 16'h007F, 16'h0001, 1, 0, 0, "R6 byte add overflow");
        step(2'd0, 1, 16'h7FFF, 16'h0001, 1, 0, 0, "R6 word add overflow");
        step(2'd1, 0, 16'h0080, 16'h0001, 1, 0, 0, "R6 byte sub overflow");
        step(2'd1, 1, 16'h0000, 16'h0001, 1, 0, 0, "R2 word sub borrow");
        step(2'd1, 0, 16'h0010, 16'h0001, 1, 0, 0, "R3 sub nibble borrow");
        step(2'd0, 0, 16'h0008, 16'h0008, 1, 0, 0, "R3 add nibble carry");
        step(2'd0, 1, 16'h0300, 16'h0000, 1, 0, 0, "R4 word parity low byte");
        step(2'd0, 1, 16'h8000, 16'h8000, 1, 0, 0, "R5 word zero carry");
        step(2'd2, 1, 16'hF0F1, 16'hFFFF, 1, 0, 0, "R7 logic keeps AF");
        step(2'd0, 0, 16'h0001, 16'h0001, 0, 0, 0, "R10 enable low");
        step(2'd3, 0, 16'h00FF, 16'h0001, 1, 0, 0, "R10 kind none");
        step(2'd3, 0, 0, 0, 0, 3'b111, 3'b000, "R8 set all");
        step(2'd0, 1, 16'hFFFF, 16'h0001, 1, 0, 0, "R8 update keeps ctl");
        step(2'd3, 0, 0, 0, 0, 3'b101, 3'b101, "R8 clear wins");

        for (int n = 0; n < 600; n++) begin
            logic [1:0] k;
            logic [15:0] a, b;
            k = 2'($urandom_range(3, 0));
            a = 16'($urandom);
            b = 16'($urandom);
            if (n % 7 == 0) b = a;
            if (n % 11 == 0) b = 16'(-a);
            step(k, bit'($urandom_range(1, 0)), a, b,
                 ($urandom_range(7, 0) != 0),
                 ($urandom_range(3, 0) == 0) ? 3'($urandom) : 3'b000,
                 ($urandom_range(3, 0) == 0) ? 3'($urandom) : 3'b000,
                 "random");
        end

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule